// File: doc/BRIEF.md
# Frame Header Decode and Fetch Sequencer

This block sits between a display controller's register file and its pixel pipeline. Once the controller is switched on, it checks that the frame buffer bounds are legal. It then fetches a 512-byte palette header from the top of buffer 0 with a valid/ready request and keeps the first palette entry. The depth code in that entry sets the pixel depth and tells the block where the pixel data starts, past either a short or a full header.

For every refresh tick it accepts, the block does four things. It works out the pixel base address, the line stride in bytes, the bits per pixel, and the first line and line count after an optional subpanel trim. It checks that the header and the pixel data fit inside the active buffer. If they do, it presents all results together with a one-cycle frame-start strobe, marks the buffer as consumed and, in dual-buffer mode, swaps to the other buffer. If the frame does not fit, it flags a sync error and stops itself. Palette lookup and pixel drawing happen downstream.

Top module: `fhd_frame_seq`

## Requirements
- R1: While reset is asserted and just after it is released, every output is zero, no fetch request is raised, and the block is inactive.
- R2: On a rising `enable_i` with legal bounds and a load mode other than 2, the block raises `rd_valid_o` the next cycle with `rd_addr_o` equal to `buf0_top_i`. It holds both unchanged until `rd_ready_i`. The 16-bit word accepted with `hdr_valid_i` appears on `hdr_entry_o`, and `hdr_loaded_o` rises. The header is fetched only once per enable.
- R3: In load mode 2 there is no header fetch and `hdr_loaded_o` stays 0. The pixel data offset is 0. The depth comes from the most recently captured header entry, which is zero after reset.
- R4: The depth code is bits 14:12 of the header entry. Code 1 gives 2 bpp, code 2 gives 4, code 3 gives 8, and codes 4 to 7 give 16. Code 0 drops the tick: no strobe, and no change to the buffer index or the condition bits.
- R5: `pix_base_o` is the top of the active buffer plus an offset. The offset is 0x200 for depth codes 3 and above and 0x20 for codes 1 and 2, outside load mode 2.
- R6: `stride_o` equals floor(width * bpp / 8).
- R7: A frame fails when offset + floor(width*height*bpp/8) is greater than (bottom - top) + 2 of the active buffer. A failing frame sets `sync_err_o`, clears `active_o` and gives no strobe. A frame that fills the buffer exactly to that limit is accepted.
- R8: An accepted frame gives `frm_start_o` for one cycle, in the cycle after the edge that sampled the tick. In that same cycle it sets `cond_o[N]` for buffer N and pulses `cmpl_irq_o` if `cmpl_irq_en_i` is set.
- R9: With `dual_i` set, the buffer index toggles after every accepted frame. Without it, the index stays 0.
- R10: At enable, bit 0 and bit 1 of `addr_ok_i` are the validity of buffer 0's top and bottom addresses. Bit 2 and bit 3 are the validity of buffer 1's top and bottom, and they are checked only when `dual_i` is set. Any invalid bound sets `cond_o[2]`, pulses `err_irq_o` if `err_irq_en_i` is set, and leaves the block inactive with no fetch.
- R11: With `sub_en_i` set, `sub_lines_i` becomes the first line if `sub_first_i` is set, and otherwise it becomes the line count. Without `sub_en_i`, the first line is 0 and the count is `height_i`.
- R12: A tick is ignored in load mode 1, while inactive, and before the header has loaded (in modes other than 2).
- R13: A falling `enable_i` clears `active_o` and `sync_err_o`. A rising `enable_i` clears the buffer index and the consumed bits of `cond_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Controller enable level |
| load_mode_i | input | 2 | 0/3 header+data, 1 header only, 2 data only |
| dual_i | input | 1 | Alternate between two buffers |
| cmpl_irq_en_i | input | 1 | Enable frame-completion interrupt |
| err_irq_en_i | input | 1 | Enable bounds-error interrupt |
| width_i | input | DW | Line width in pixels |
| height_i | input | DW | Frame height in lines |
| sub_en_i | input | 1 | Subpanel trim enable |
| sub_first_i | input | 1 | Trim selects first line (1) or line count (0) |
| sub_lines_i | input | DW | Subpanel line value |
| buf0_top_i | input | AW | Buffer 0 start address |
| buf0_bot_i | input | AW | Buffer 0 end address |
| buf1_top_i | input | AW | Buffer 1 start address |
| buf1_bot_i | input | AW | Buffer 1 end address |
| addr_ok_i | input | 4 | Address-valid flags: b0/b1 buffer 0 top/bottom, b2/b3 buffer 1 |
| frame_tick_i | input | 1 | Refresh request |
| rd_valid_o | output | 1 | Header fetch request |
| rd_ready_i | input | 1 | Header fetch accepted |
| rd_addr_o | output | AW | Header fetch address |
| hdr_valid_i | input | 1 | Header entry 0 returned |
| hdr_word_i | input | 16 | Header entry 0 value |
| hdr_entry_o | output | 16 | Captured header entry 0 |
| hdr_loaded_o | output | 1 | Header captured since enable |
| active_o | output | 1 | Sequencer running |
| cur_buf_o | output | 1 | Buffer used by the next frame |
| cond_o | output | 3 | Sticky: b0/b1 buffer consumed, b2 bounds error |
| sync_err_o | output | 1 | Frame overflowed its buffer |
| cmpl_irq_o | output | 1 | Completion interrupt pulse |
| err_irq_o | output | 1 | Bounds-error interrupt pulse |
| frm_start_o | output | 1 | Results valid strobe |
| frm_buf_o | output | 1 | Buffer of the presented frame |
| pix_base_o | output | AW | Pixel data start address |
| stride_o | output | DW+1 | Line stride in bytes |
| bpp_o | output | 5 | Bits per pixel |
| first_line_o | output | DW | First displayed line |
| line_cnt_o | output | DW | Displayed line count |

## Verification
Every result is registered once. The fetch request and the bounds-error outputs appear in the cycle after the edge that sees the enable change. Frame results, the strobe, the condition bit and the completion pulse appear in the cycle after the edge that samples the tick. The header capture shows on `hdr_loaded_o` one cycle after the edge where `hdr_valid_i` is high. The bench drives inputs on the falling edge and samples one falling edge after the edge that should act. The one deliberate stall on `rd_ready_i` is checked a full cycle later, to prove the request holds.

// File: rtl/fhd_pkg.sv
package fhd_pkg;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_WAIT = 2'd2
  } fetch_st_e;

  localparam logic [1:0] LM_HDR_ONLY  = 2'd1;
  localparam logic [1:0] LM_DATA_ONLY = 2'd2;

  // log2 of bits per pixel for a header depth code; 0 marks a dropped frame
  function automatic logic [2:0] depth_lg2(input logic [2:0] code);
    case (code)
      3'd0:    return 3'd0;
      3'd1:    return 3'd1;
      3'd2:    return 3'd2;
      3'd3:    return 3'd3;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/fhd_hdr_fetch.sv
module fhd_hdr_fetch #(
  parameter int AW = 24,
  parameter int EW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic [AW-1:0] base_i,
  output logic          rd_valid_o,
  input  logic          rd_ready_i,
  output logic [AW-1:0] rd_addr_o,
  input  logic          hdr_valid_i,
  input  logic [EW-1:0] hdr_word_i,
  output logic [EW-1:0] entry_o,
  output logic          loaded_o
);
  import fhd_pkg::*;

  fetch_st_e     st_q, st_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [EW-1:0] ent_q, ent_d;
  logic          ld_q, ld_d;

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    ent_d  = ent_q;
    ld_d   = ld_q;
    if (abort_i) begin
      st_d = FS_IDLE;
      ld_d = 1'b0;
    end else if (start_i) begin
      st_d   = FS_REQ;
      addr_d = base_i;
      ld_d   = 1'b0;
    end else begin
      case (st_q)
        FS_REQ:  if (rd_ready_i) st_d = FS_WAIT;
        FS_WAIT: if (hdr_valid_i) begin
          ent_d = hdr_word_i;
          ld_d  = 1'b1;
          st_d  = FS_IDLE;
        end
        default: st_d = FS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FS_IDLE;
      addr_q <= '0;
      ent_q  <= '0;
      ld_q   <= 1'b0;
    end else begin
      st_q <= st_d;
      ld_q <= ld_d;
      if (start_i) addr_q <= addr_d;
      if (st_q == FS_WAIT) ent_q <= ent_d;
    end
  end

  assign rd_valid_o = (st_q == FS_REQ);
  assign rd_addr_o  = addr_q;
  assign entry_o    = ent_q;
  assign loaded_o   = ld_q;

endmodule

// File: rtl/fhd_geom.sv
module fhd_geom #(
  parameter int AW          = 24,
  parameter int DW          = 10,
  parameter int HDR_BYTES   = 512,
  parameter int SHORT_BYTES = 32
) (
  input  logic [2:0]    code_i,
  input  logic          data_only_i,
  input  logic [DW-1:0] w_i,
  input  logic [DW-1:0] h_i,
  input  logic          sub_en_i,
  input  logic          sub_first_i,
  input  logic [DW-1:0] sub_lines_i,
  input  logic [AW-1:0] top_i,
  input  logic [AW-1:0] bot_i,
  output logic          skip_o,
  output logic          ovf_o,
  output logic [4:0]    bpp_o,
  output logic [AW-1:0] base_o,
  output logic [DW:0]   stride_o,
  output logic [DW-1:0] first_o,
  output logic [DW-1:0] cnt_o
);
  import fhd_pkg::*;

  localparam int CW = (2*DW + 5 > AW + 2) ? 2*DW + 5 : AW + 2;

  logic [2:0]      lg;
  logic [2*DW-1:0] area;
  logic [CW-1:0]   bytes, off, size;
  logic [DW+4:0]   line_bits;

  always_comb begin
    lg        = depth_lg2(code_i);
    skip_o    = (lg == 3'd0);
    bpp_o     = 5'd1 << lg;
    area      = (2*DW)'(w_i) * (2*DW)'(h_i);
    bytes     = (CW'(area) << lg) >> 3;
    line_bits = (DW+5)'(w_i) << lg;
    stride_o  = (DW+1)'(line_bits >> 3);
    if (data_only_i)          off = '0;
    else if (code_i >= 3'd3)  off = CW'(HDR_BYTES);
    else                      off = CW'(SHORT_BYTES);
    size   = CW'(bot_i) - CW'(top_i);
    ovf_o  = (off + bytes) > (size + CW'(2));
    base_o = top_i + off[AW-1:0];
    first_o = '0;
    cnt_o   = h_i;
    if (sub_en_i) begin
      if (sub_first_i) first_o = sub_lines_i;
      else             cnt_o   = sub_lines_i;
    end
  end

endmodule

// File: rtl/fhd_frame_seq.sv
module fhd_frame_seq #(
  parameter int AW          = 24,
  parameter int DW          = 10,
  parameter int HDR_BYTES   = 512,
  parameter int SHORT_BYTES = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable_i,
  input  logic [1:0]    load_mode_i,
  input  logic          dual_i,
  input  logic          cmpl_irq_en_i,
  input  logic          err_irq_en_i,
  input  logic [DW-1:0] width_i,
  input  logic [DW-1:0] height_i,
  input  logic          sub_en_i,
  input  logic          sub_first_i,
  input  logic [DW-1:0] sub_lines_i,
  input  logic [AW-1:0] buf0_top_i,
  input  logic [AW-1:0] buf0_bot_i,
  input  logic [AW-1:0] buf1_top_i,
  input  logic [AW-1:0] buf1_bot_i,
  input  logic [3:0]    addr_ok_i,
  input  logic          frame_tick_i,
  output logic          rd_valid_o,
  input  logic          rd_ready_i,
  output logic [AW-1:0] rd_addr_o,
  input  logic          hdr_valid_i,
  input  logic [15:0]   hdr_word_i,
  output logic [15:0]   hdr_entry_o,
  output logic          hdr_loaded_o,
  output logic          active_o,
  output logic          cur_buf_o,
  output logic [2:0]    cond_o,
  output logic          sync_err_o,
  output logic          cmpl_irq_o,
  output logic          err_irq_o,
  output logic          frm_start_o,
  output logic          frm_buf_o,
  output logic [AW-1:0] pix_base_o,
  output logic [DW:0]   stride_o,
  output logic [4:0]    bpp_o,
  output logic [DW-1:0] first_line_o,
  output logic [DW-1:0] line_cnt_o
);
  import fhd_pkg::*;

  // reset synchronizer: assert asynchronously, release on the clock
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  logic en_q, act_q, cur_q, serr_q, irqc_q, irqe_q, frm_q, fbuf_q;
  logic en_rise, en_fall, bounds_ok, data_only, fetch_go, go, accept, overflow;
  logic act_d, cur_d, serr_d;
  logic [2:0] cond_q, cond_d;

  logic          g_skip, g_ovf;
  logic [4:0]    g_bpp;
  logic [AW-1:0] g_base, act_top, act_bot;
  logic [DW:0]   g_stride;
  logic [DW-1:0] g_first, g_cnt;
  logic [AW-1:0] base_q;
  logic [DW:0]   stride_q;
  logic [4:0]    bpp_q;
  logic [DW-1:0] first_q, cnt_q;

  assign en_rise   = enable_i & ~en_q;
  assign en_fall   = ~enable_i & en_q;
  assign bounds_ok = addr_ok_i[0] & addr_ok_i[1] & (~dual_i | (addr_ok_i[2] & addr_ok_i[3]));
  assign data_only = (load_mode_i == LM_DATA_ONLY);
  assign fetch_go  = en_rise & bounds_ok & ~data_only;

  fhd_hdr_fetch #(.AW(AW), .EW(16)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .start_i    (fetch_go),
    .abort_i    (en_fall | (en_rise & ~fetch_go)),
    .base_i     (buf0_top_i),
    .rd_valid_o (rd_valid_o),
    .rd_ready_i (rd_ready_i),
    .rd_addr_o  (rd_addr_o),
    .hdr_valid_i(hdr_valid_i),
    .hdr_word_i (hdr_word_i),
    .entry_o    (hdr_entry_o),
    .loaded_o   (hdr_loaded_o)
  );

  assign act_top = cur_q ? buf1_top_i : buf0_top_i;
  assign act_bot = cur_q ? buf1_bot_i : buf0_bot_i;

  fhd_geom #(.AW(AW), .DW(DW), .HDR_BYTES(HDR_BYTES), .SHORT_BYTES(SHORT_BYTES)) u_geom (
    .code_i     (hdr_entry_o[14:12]),
    .data_only_i(data_only),
    .w_i        (width_i),
    .h_i        (height_i),
    .sub_en_i   (sub_en_i),
    .sub_first_i(sub_first_i),
    .sub_lines_i(sub_lines_i),
    .top_i      (act_top),
    .bot_i      (act_bot),
    .skip_o     (g_skip),
    .ovf_o      (g_ovf),
    .bpp_o      (g_bpp),
    .base_o     (g_base),
    .stride_o   (g_stride),
    .first_o    (g_first),
    .cnt_o      (g_cnt)
  );

  assign go       = act_q & enable_i & frame_tick_i & (load_mode_i != LM_HDR_ONLY)
                    & (data_only | hdr_loaded_o);
  assign accept   = go & ~g_skip & ~g_ovf;
  assign overflow = go & ~g_skip & g_ovf;

  always_comb begin
    act_d  = act_q;
    cur_d  = cur_q;
    serr_d = serr_q;
    cond_d = cond_q | (accept ? (3'b001 << cur_q) : 3'b000);
    if (en_rise) begin
      act_d  = bounds_ok;
      cur_d  = 1'b0;
      serr_d = 1'b0;
      cond_d = {~bounds_ok, 2'b00};
    end else if (en_fall) begin
      act_d  = 1'b0;
      serr_d = 1'b0;
    end else if (overflow) begin
      act_d  = 1'b0;
      serr_d = 1'b1;
    end else if (accept & dual_i) begin
      cur_d = ~cur_q;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      en_q   <= 1'b0;
      act_q  <= 1'b0;
      cur_q  <= 1'b0;
      serr_q <= 1'b0;
      cond_q <= 3'b000;
      irqc_q <= 1'b0;
      irqe_q <= 1'b0;
      frm_q  <= 1'b0;
    end else begin
      en_q   <= enable_i;
      act_q  <= act_d;
      cur_q  <= cur_d;
      serr_q <= serr_d;
      cond_q <= cond_d;
      irqc_q <= accept & cmpl_irq_en_i;
      irqe_q <= en_rise & ~bounds_ok & err_irq_en_i;
      frm_q  <= accept;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      fbuf_q   <= 1'b0;
      base_q   <= '0;
      stride_q <= '0;
      bpp_q    <= '0;
      first_q  <= '0;
      cnt_q    <= '0;
    end else if (accept) begin
      fbuf_q   <= cur_q;
      base_q   <= g_base;
      stride_q <= g_stride;
      bpp_q    <= g_bpp;
      first_q  <= g_first;
      cnt_q    <= g_cnt;
    end
  end

  assign active_o     = act_q;
  assign cur_buf_o    = cur_q;
  assign cond_o       = cond_q;
  assign sync_err_o   = serr_q;
  assign cmpl_irq_o   = irqc_q;
  assign err_irq_o    = irqe_q;
  assign frm_start_o  = frm_q;
  assign frm_buf_o    = fbuf_q;
  assign pix_base_o   = base_q;
  assign stride_o     = stride_q;
  assign bpp_o        = bpp_q;
  assign first_line_o = first_q;
  assign line_cnt_o   = cnt_q;

endmodule

// File: rtl/fhd_frame_seq_chk.sv
module fhd_frame_seq_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    load_mode_i,
  input logic          dual_i,
  input logic          rd_valid_o,
  input logic          rd_ready_i,
  input logic [AW-1:0] rd_addr_o,
  input logic          active_o,
  input logic          cur_buf_o,
  input logic [2:0]    cond_o,
  input logic          sync_err_o,
  input logic          cmpl_irq_o,
  input logic          err_irq_o,
  input logic          frm_start_o,
  input logic          frm_buf_o,
  input logic [4:0]    bpp_o
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_addr_o)); // R2

  AST_NO_FETCH_DATA_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_o) && ($past(load_mode_i) == 2'd2) |-> !rd_valid_o); // R3

  AST_BPP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start_o |-> ($countones(bpp_o) == 1) && (bpp_o >= 5'd2)); // R4

  AST_NO_STROBE_SERR: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start_o |-> !sync_err_o); // R7

  AST_SERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_err_o) |-> !active_o); // R7

  AST_CMPL_WITH_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_irq_o |-> frm_start_o); // R8

  AST_COND_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start_o |-> cond_o[frm_buf_o]); // R8

  AST_DUAL_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start_o && $past(dual_i) |-> cur_buf_o != frm_buf_o); // R9

  AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start_o && !$past(dual_i) |-> cur_buf_o == frm_buf_o); // R9

  AST_BOUNDS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq_o |-> !active_o && cond_o[2] && !rd_valid_o); // R10

  AST_HDR_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start_o |-> $past(load_mode_i) != 2'd1); // R12

endmodule

bind fhd_frame_seq fhd_frame_seq_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_fhd_frame_seq.sv
`timescale 1ns/1ps
module tb_fhd_frame_seq;
  localparam int AW = 24;
  localparam int DW = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic enable_i, dual_i, cmpl_irq_en_i, err_irq_en_i, sub_en_i, sub_first_i;
  logic [1:0] load_mode_i;
  logic [DW-1:0] width_i, height_i, sub_lines_i;
  logic [AW-1:0] buf0_top_i, buf0_bot_i, buf1_top_i, buf1_bot_i;
  logic [3:0] addr_ok_i;
  logic frame_tick_i, rd_ready_i, hdr_valid_i;
  logic [15:0] hdr_word_i;
  logic rd_valid_o, hdr_loaded_o, active_o, cur_buf_o, sync_err_o, cmpl_irq_o, err_irq_o;
  logic frm_start_o, frm_buf_o;
  logic [AW-1:0] rd_addr_o, pix_base_o;
  logic [15:0] hdr_entry_o;
  logic [2:0] cond_o;
  logic [DW:0] stride_o;
  logic [4:0] bpp_o;
  logic [DW-1:0] first_line_o, line_cnt_o;

  always #5 clk = ~clk;

  fhd_frame_seq dut (.*);

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  int exp_cur = 0;
  int code = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input longint act, input longint exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic enable_fetch(input logic [15:0] word, input bit early_tick);
    @(negedge clk) enable_i = 1'b1;
    @(negedge clk);
    eq("R2 req", rd_valid_o, 1);
    eq("R2 addr", rd_addr_o, buf0_top_i);
    if (early_tick) frame_tick_i = 1'b1;
    @(negedge clk) frame_tick_i = 1'b0;
    if (early_tick) eq("R12 before header", frm_start_o, 0);
    eq("R2 hold", rd_valid_o, 1);
    rd_ready_i = 1'b1;
    @(negedge clk) rd_ready_i = 1'b0;
    eq("R2 drop", rd_valid_o, 0);
    hdr_valid_i = 1'b1; hdr_word_i = word;
    @(negedge clk) hdr_valid_i = 1'b0;
    eq("R2 loaded", hdr_loaded_o, 1);
    eq("R2 entry", hdr_entry_o, word);
    eq("R13 cond clear", cond_o, 0);
    exp_cur = 0;
    code = int'(word[14:12]);
  endtask

  task automatic disable_ctl();
    @(negedge clk) enable_i = 1'b0;
    @(negedge clk);
    eq("R13 inactive", active_o, 0);
    eq("R13 serr clear", sync_err_o, 0);
  endtask

  task automatic frame();
    int lg, bpp, off, bytes, size, top, bot, fl, cnt;
    lg = (code == 0) ? 0 : (code >= 4 ? 4 : code);
    bpp = 1 << lg;
    off = (load_mode_i == 2'd2) ? 0 : (code >= 3 ? 512 : 32);
    bytes = (int'(width_i) * int'(height_i) * bpp) / 8;
    top = (exp_cur == 1) ? int'(buf1_top_i) : int'(buf0_top_i);
    bot = (exp_cur == 1) ? int'(buf1_bot_i) : int'(buf0_bot_i);
    size = bot - top;
    fl = (sub_en_i && sub_first_i) ? int'(sub_lines_i) : 0;
    cnt = (sub_en_i && !sub_first_i) ? int'(sub_lines_i) : int'(height_i);
    @(negedge clk) frame_tick_i = 1'b1;
    @(negedge clk) frame_tick_i = 1'b0;
    if (code == 0) begin
      eq("R4 code0 no strobe", frm_start_o, 0);
      eq("R4 code0 buf kept", cur_buf_o, exp_cur);
      eq("R4 code0 cond", cond_o, 0);
    end else if (off + bytes > size + 2) begin
      eq("R7 no strobe", frm_start_o, 0);
      eq("R7 serr", sync_err_o, 1);
      eq("R7 stopped", active_o, 0);
    end else begin
      eq("R8 strobe", frm_start_o, 1);
      eq("R8 frame buf", frm_buf_o, exp_cur);
      eq("R8 cond bit", cond_o[exp_cur], 1);
      eq("R8 cmpl irq", cmpl_irq_o, cmpl_irq_en_i);
      eq("R4 bpp", bpp_o, bpp);
      eq("R5 base", pix_base_o, top + off);
      eq("R6 stride", stride_o, (int'(width_i) * bpp) / 8);
      eq("R11 first", first_line_o, fl);
      eq("R11 count", line_cnt_o, cnt);
      if (dual_i) exp_cur = 1 - exp_cur;
      eq("R9 next buf", cur_buf_o, exp_cur);
      @(negedge clk);
      eq("R8 one-cycle strobe", frm_start_o, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int widths[3] = '{1, 3, 10};
    rst_n = 1'b0; enable_i = 0; load_mode_i = 0; dual_i = 0; cmpl_irq_en_i = 0;
    err_irq_en_i = 0; width_i = 4; height_i = 4; sub_en_i = 0; sub_first_i = 0;
    sub_lines_i = 0; buf0_top_i = 24'h001000; buf0_bot_i = 24'h009000;
    buf1_top_i = 24'h020000; buf1_bot_i = 24'h028000; addr_ok_i = 4'hf;
    frame_tick_i = 0; rd_ready_i = 0; hdr_valid_i = 0; hdr_word_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    eq("R1 rd_valid", rd_valid_o, 0);
    eq("R1 active", active_o, 0);
    eq("R1 strobe", frm_start_o, 0);
    eq("R1 cond", cond_o, 0);
    eq("R1 loaded", hdr_loaded_o, 0);
    eq("R1 base", pix_base_o, 0);

    // R12 tick while inactive
    @(negedge clk) frame_tick_i = 1'b1;
    @(negedge clk) frame_tick_i = 1'b0;
    eq("R12 inactive tick", frm_start_o, 0);

    // sweep over depth codes, widths and subpanel modes (R4 R5 R6 R8 R9 R11)
    for (int c = 0; c < 8; c++) begin
      for (int wi = 0; wi < 3; wi++) begin
        for (int s = 0; s < 3; s++) begin
          width_i = widths[wi][DW-1:0];
          height_i = DW'(wi + 2);
          dual_i = c[0];
          cmpl_irq_en_i = wi[0];
          sub_en_i = (s != 0);
          sub_first_i = (s == 1);
          sub_lines_i = DW'(s + 1);
          enable_fetch({1'b0, 3'(c), 12'h0a5 + 12'(wi)}, (c == 1 && wi == 0 && s == 0));
          frame();
          frame();
          frame();
          disable_ctl();
        end
      end
    end
    sub_en_i = 0; dual_i = 0;

    // R7 boundary: code 3, 4x4 -> 512+16 = 528; size 526 fits exactly
    width_i = 4; height_i = 4; buf0_bot_i = buf0_top_i + 24'd526;
    enable_fetch(16'h3000, 0);
    frame();
    disable_ctl();
    buf0_bot_i = buf0_top_i + 24'd525;
    enable_fetch(16'h3000, 0);
    frame();
    eq("R7 serr kept", sync_err_o, 1);
    disable_ctl();
    buf0_bot_i = 24'h009000;

    // R10 bounds invalid in dual mode
    addr_ok_i = 4'b1011; dual_i = 1; err_irq_en_i = 1;
    @(negedge clk) enable_i = 1'b1;
    @(negedge clk);
    eq("R10 err irq", err_irq_o, 1);
    eq("R10 cond2", cond_o, 3'b100);
    eq("R10 inactive", active_o, 0);
    eq("R10 no fetch", rd_valid_o, 0);
    disable_ctl();
    // buffer 1 bounds ignored without dual
    dual_i = 0;
    enable_fetch(16'h2000, 0);
    eq("R10 single ok", active_o, 1);
    disable_ctl();
    addr_ok_i = 4'hf;

    // R3 data-only mode reuses entry (code 2 -> 4 bpp, offset 0)
    load_mode_i = 2'd2;
    @(negedge clk) enable_i = 1'b1;
    @(negedge clk);
    eq("R3 no fetch", rd_valid_o, 0);
    eq("R3 not loaded", hdr_loaded_o, 0);
    exp_cur = 0;
    frame();
    disable_ctl();

    // R12 header-only mode processes no frame
    load_mode_i = 2'd1;
    enable_fetch(16'h3000, 0);
    @(negedge clk) frame_tick_i = 1'b1;
    @(negedge clk) frame_tick_i = 1'b0;
    eq("R12 mode1 no strobe", frm_start_o, 0);
    eq("R12 mode1 cond", cond_o, 0);
    disable_ctl();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule